// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device side of a disk task file. A host reaches it through eight byte-wide register slots selected by a 3-bit address, with single-cycle read and write strobes. It holds the parameter registers, decodes command bytes and moves through three phases: idle, data-out and busy-wait. It drives a status byte and an interrupt request line.

Identify returns a 256-word buffer through the 16-bit data slot. Cache flush and the three DMA-class opcodes hold the device busy until a completion pulse arrives from the media side. Media access and DMA data movement sit outside the block.

Reading the status slot acknowledges the interrupt. Accepting a new command also drops any interrupt still pending.

Top module: `ata_taskfile`

## Requirements
- R1: Slots 2, 3, 4, 5 and 6 (sector count, LBA low, mid, high, device) are 8-bit registers. A byte written to one reads back at the same slot with bits 15:8 of the read data zero.
- R2: After reset, status (slot 7) reads 0x40, slot 1 (error) reads 0 and the interrupt is low. The ready bit (status bit 6) stays set at all times.
- R3: Opcode 0xEC starts a data-out phase in the next cycle. Status reads 0x48 (ready, bit 3 data-request) and the interrupt rises. Each slot-0 read returns one word: word 0 is 0x0040, word 49 is 0x0200, word 85 is 0x0020 (bit 5 means write cache enabled), and all other words are 0.
- R4: After the 256th word read, status returns to 0x40. A further slot-0 read returns 0.
- R5: Opcode 0xE7 makes status read 0xC0 (bit 7 busy, ready) with no interrupt, until the completion input is pulsed.
- R6: Opcodes 0xC8, 0xCA and 0xA0 behave like 0xE7. In the cycle after a completion pulse during busy, status reads 0x40 and the interrupt is high.
- R7: Reading slot 7 clears the interrupt at that clock edge. Reads of other slots leave it unchanged.
- R8: Any other opcode sets status bit 0 (status 0x41), sets error slot bit 2 (reads 0x04) and raises the interrupt. The next accepted opcode clears both bits.
- R9: A command write while busy or in data-out is ignored. The running phase and the word sequence continue unchanged.
- R10: With parameter HAS_DEV1 = 0 and device-register bit 4 set, a command write is ignored: status stays 0x40 and no interrupt is raised.
- R11: A completion pulse while idle has no effect on status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 3 | Register slot select |
| host_wr_i | input | 1 | Write strobe, one cycle per access |
| host_rd_i | input | 1 | Read strobe; side effects apply at the clock edge |
| host_wdata_i | input | 16 | Write data; bits 7:0 for byte slots |
| host_rdata_o | output | 16 | Combinational read data for the addressed slot |
| op_done_i | input | 1 | Completion pulse for busy-wait commands |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
Read data is combinational, so a read returns the current state in the same cycle as its strobe. Its side effects (word advance, interrupt acknowledge) land on the following clock edge. A command write or completion pulse changes status and the interrupt at the edge that samples it, so they are visible one cycle later. The bench drives each strobe on a falling edge and samples read data one time unit later. It checks the interrupt and the next status read after the falling edge that ends the access. Every expected status value therefore belongs to exactly one edge.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [2:0] SLOT_DATA = 3'd0;
  localparam logic [2:0] SLOT_ERR  = 3'd1;
  localparam logic [2:0] SLOT_CNT  = 3'd2;
  localparam logic [2:0] SLOT_LBA0 = 3'd3;
  localparam logic [2:0] SLOT_LBA1 = 3'd4;
  localparam logic [2:0] SLOT_LBA2 = 3'd5;
  localparam logic [2:0] SLOT_DEV  = 3'd6;
  localparam logic [2:0] SLOT_CMD  = 3'd7;

  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;
  localparam logic [7:0] OP_DMARD = 8'hC8;
  localparam logic [7:0] OP_DMAWR = 8'hCA;
  localparam logic [7:0] OP_PKT   = 8'hA0;

  localparam int DEV_SEL_BIT = 4;
  localparam int ABORT_BIT   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_WAIT} seq_state_e;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] cnt_o,
  output logic [7:0] lba0_o,
  output logic [7:0] lba1_o,
  output logic [7:0] lba2_o,
  output logic [7:0] dev_o,
  output logic [7:0] feat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      lba0_o <= '0;
      lba1_o <= '0;
      lba2_o <= '0;
      dev_o  <= '0;
      feat_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        SLOT_ERR:  feat_o <= wdata_i;
        SLOT_CNT:  cnt_o  <= wdata_i;
        SLOT_LBA0: lba0_o <= wdata_i;
        SLOT_LBA1: lba1_o <= wdata_i;
        SLOT_LBA2: lba2_o <= wdata_i;
        SLOT_DEV:  dev_o  <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
  parameter int WORDS      = 256,
  parameter int LBA_WORD   = 49,
  parameter int CACHE_WORD = 85,
  parameter bit WCACHE_ON  = 1'b1,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [15:0]      word_o
);
  always_comb begin
    word_o = '0;
    if (idx_i == '0)                    word_o = 16'h0040;
    else if (idx_i == IDX_W'(LBA_WORD))   word_o = 16'h0200;
    else if (idx_i == IDX_W'(CACHE_WORD)) word_o = {10'd0, WCACHE_ON, 5'd0};
  end
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
#(
  parameter int WORDS    = 256,
  parameter bit HAS_DEV1 = 1'b0,
  localparam int IDX_W   = $clog2(WORDS),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [7:0]       cmd_i,
  input  logic             dev1_sel_i,
  input  logic             data_rd_i,
  input  logic             stat_rd_i,
  input  logic             op_done_i,
  output seq_state_e       state_o,
  output logic             err_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] widx_o
);
  logic accept, irq_set, irq_clr;

  assign accept = cmd_wr_i && (state_o == ST_IDLE) && !(dev1_sel_i && !HAS_DEV1);

  always_comb begin
    irq_set = 1'b0;
    if (accept)
      irq_set = (cmd_i == OP_IDENT) || !(cmd_i inside {OP_FLUSH, OP_DMARD, OP_DMAWR, OP_PKT});
    else if (state_o == ST_WAIT && op_done_i)
      irq_set = 1'b1;
  end
  // accepting a command also drops any stale request
  assign irq_clr = stat_rd_i || accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      err_o   <= 1'b0;
      irq_o   <= 1'b0;
      widx_o  <= '0;
    end else begin
      irq_o <= irq_set ? 1'b1 : (irq_clr ? 1'b0 : irq_o);
      unique case (state_o)
        ST_IDLE: if (accept) begin
          err_o  <= 1'b0;
          widx_o <= '0;
          case (cmd_i)
            OP_IDENT: state_o <= ST_XFER;
            OP_FLUSH, OP_DMARD, OP_DMAWR, OP_PKT: state_o <= ST_WAIT;
            default: err_o <= 1'b1;
          endcase
        end
        ST_XFER: if (data_rd_i) begin
          if (widx_o == LAST) state_o <= ST_IDLE;
          else widx_o <= widx_o + 1'b1;
        end
        ST_WAIT: if (op_done_i) state_o <= ST_IDLE;
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int WORDS    = 256,
  parameter bit HAS_DEV1 = 1'b0,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  host_addr_i,
  input  logic        host_wr_i,
  input  logic        host_rd_i,
  input  logic [15:0] host_wdata_i,
  output logic [15:0] host_rdata_o,
  input  logic        op_done_i,
  output logic        irq_o
);
  logic [7:0] cnt, lba0, lba1, lba2, dev_w, feat;
  logic [7:0] status_w;
  logic [15:0] id_word;
  logic [IDX_W-1:0] widx;
  logic err;
  seq_state_e state;

  ata_tf_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(host_wr_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i[7:0]),
    .cnt_o(cnt), .lba0_o(lba0), .lba1_o(lba1), .lba2_o(lba2),
    .dev_o(dev_w), .feat_o(feat)
  );

  ata_tf_seq #(.WORDS(WORDS), .HAS_DEV1(HAS_DEV1)) u_seq (
    .clk_i, .rst_ni,
    .cmd_wr_i(host_wr_i && host_addr_i == SLOT_CMD),
    .cmd_i(host_wdata_i[7:0]),
    .dev1_sel_i(dev_w[DEV_SEL_BIT]),
    .data_rd_i(host_rd_i && host_addr_i == SLOT_DATA),
    .stat_rd_i(host_rd_i && host_addr_i == SLOT_CMD),
    .op_done_i,
    .state_o(state), .err_o(err), .irq_o, .widx_o(widx)
  );

  ata_tf_ident #(.WORDS(WORDS)) u_ident (.idx_i(widx), .word_o(id_word));

  assign status_w = {state == ST_WAIT, 1'b1, 2'b00, state == ST_XFER, 2'b00, err};

  always_comb begin
    host_rdata_o = '0;
    case (host_addr_i)
      SLOT_DATA: host_rdata_o = (state == ST_XFER) ? id_word : 16'h0;
      SLOT_ERR:  host_rdata_o = {8'h0, 5'd0, err, 2'b00};
      SLOT_CNT:  host_rdata_o = {8'h0, cnt};
      SLOT_LBA0: host_rdata_o = {8'h0, lba0};
      SLOT_LBA1: host_rdata_o = {8'h0, lba1};
      SLOT_LBA2: host_rdata_o = {8'h0, lba2};
      SLOT_DEV:  host_rdata_o = {8'h0, dev_w};
      default:   host_rdata_o = {8'h0, status_w};
    endcase
  end

  logic unused_feat;
  assign unused_feat = ^feat;
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
  parameter bit HAS_DEV1 = 1'b0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  host_addr_i,
  input logic        host_wr_i,
  input logic        host_rd_i,
  input logic [15:0] host_wdata_i,
  input logic        op_done_i,
  input logic        irq_o,
  input logic [7:0]  status_w,
  input logic [7:0]  dev_w
);
  logic idle_ok, cmd_go, known;
  assign idle_ok = !status_w[7] && !status_w[3] && !(dev_w[4] && !HAS_DEV1);
  assign cmd_go  = host_wr_i && host_addr_i == 3'd7 && idle_ok;
  assign known   = host_wdata_i[7:0] inside {8'hEC, 8'hE7, 8'hC8, 8'hCA, 8'hA0};

  // R2
  ready_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) status_w[6]);
  // R3
  ident_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_go && host_wdata_i[7:0] == 8'hEC |=> status_w == 8'h48 && irq_o);
  // R5
  flush_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_go && host_wdata_i[7:0] == 8'hE7 |=> status_w == 8'hC0 && !irq_o);
  // R6
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[7] && op_done_i |=> status_w == 8'h40 && irq_o);
  // R7
  irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && host_addr_i == 3'd7 && status_w[7] && !op_done_i |=> !irq_o);
  // R8
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_go && !known |=> status_w[0] && irq_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[7] && !op_done_i |=> status_w[7]);
  // R10
  absent_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w == 8'h40 && dev_w[4] && !HAS_DEV1 && !(host_wr_i && host_addr_i == 3'd6)
    |=> status_w == 8'h40);
  // R9
  busy_drq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_w[7] && status_w[3]));
endmodule

bind ata_taskfile ata_taskfile_chk #(.HAS_DEV1(HAS_DEV1)) u_chk (.*);

// File: tb/test_ata_taskfile.sv
module test_ata_taskfile;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, done = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  logic [15:0] q;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_taskfile #(.WORDS(WORDS), .HAS_DEV1(1'b0)) i_ata_taskfile (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_wr_i(wr),
    .host_rd_i(rd), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .op_done_i(done), .irq_o(irq)
  );

  // {cmd, pending status, waits, final status, error slot}
  localparam logic [32:0] TBL [7] = '{
    {8'hE7, 8'hC0, 1'b1, 8'h40, 8'h00},
    {8'hC8, 8'hC0, 1'b1, 8'h40, 8'h00},
    {8'h00, 8'h41, 1'b0, 8'h41, 8'h04},
    {8'hCA, 8'hC0, 1'b1, 8'h40, 8'h00},
    {8'hA0, 8'hC0, 1'b1, 8'h40, 8'h00},
    {8'h55, 8'h41, 1'b0, 8'h41, 8'h04},
    {8'hFF, 8'h41, 1'b0, 8'h41, 8'h04}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [2:0] a, input logic w, input logic [15:0] d,
                     output logic [15:0] r);
    @(negedge clk);
    addr = a; wr = w; rd = !w; wdata = d;
    #1 r = rdata;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic pulse_done;
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  function automatic logic [15:0] id_exp(input int i);
    if (i == 0) return 16'h0040;
    if (i == 49) return 16'h0200;
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    chk("R2 irq", {15'd0, irq}, 16'h0);
    bus(3'd7, 1'b0, 0, q); chk("R2 status", q, 16'h0040);
    bus(3'd1, 1'b0, 0, q); chk("R2 error", q, 16'h0000);

    // R1 register readback
    bus(3'd2, 1'b1, 16'hAB12, q); bus(3'd2, 1'b0, 0, q); chk("R1 count", q, 16'h0012);
    bus(3'd3, 1'b1, 16'h0034, q); bus(3'd3, 1'b0, 0, q); chk("R1 lba0", q, 16'h0034);
    bus(3'd4, 1'b1, 16'h0056, q); bus(3'd4, 1'b0, 0, q); chk("R1 lba1", q, 16'h0056);
    bus(3'd5, 1'b1, 16'h0078, q); bus(3'd5, 1'b0, 0, q); chk("R1 lba2", q, 16'h0078);
    bus(3'd6, 1'b1, 16'h0040, q); bus(3'd6, 1'b0, 0, q); chk("R1 dev", q, 16'h0040);

    // R11 stray completion
    pulse_done;
    chk("R11 irq", {15'd0, irq}, 16'h0);
    bus(3'd7, 1'b0, 0, q); chk("R11 status", q, 16'h0040);

    // table walk: R5 R6 R8
    for (int k = 0; k < 7; k++) begin
      logic [7:0] c, ps, fs, es;
      logic wt;
      {c, ps, wt, fs, es} = TBL[k];
      tg = wt ? ((c == 8'hE7) ? "R5" : "R6") : "R8";
      bus(3'd7, 1'b1, {8'h0, c}, q);
      chk({tg, " irq pending"}, {15'd0, irq}, {15'd0, !wt});
      bus(3'd7, 1'b0, 0, q); chk({tg, " status pending"}, q, {8'h0, ps});
      if (wt) begin
        bus(3'd7, 1'b1, 16'h00EC, q); // R9 ignored while busy
        bus(3'd7, 1'b0, 0, q); chk("R9 busy hold", q, {8'h0, ps});
        pulse_done;
        chk({tg, " irq done"}, {15'd0, irq}, 16'h1);
        bus(3'd7, 1'b0, 0, q); chk({tg, " status done"}, q, {8'h0, fs});
      end
      chk("R7 irq acked", {15'd0, irq}, 16'h0);
      bus(3'd1, 1'b0, 0, q); chk({tg, " error slot"}, q, {8'h0, es});
    end

    // R7 other slots do not acknowledge
    bus(3'd7, 1'b1, 16'h0011, q);
    bus(3'd2, 1'b0, 0, q);
    chk("R7 irq kept", {15'd0, irq}, 16'h1);
    bus(3'd7, 1'b0, 0, q);
    chk("R7 irq cleared", {15'd0, irq}, 16'h0);

    // R3 R4 identify
    bus(3'd7, 1'b1, 16'h00EC, q);
    chk("R3 irq", {15'd0, irq}, 16'h1);
    bus(3'd1, 1'b0, 0, q); chk("R8 error cleared", q, 16'h0000);
    for (int i = 0; i < WORDS; i++) begin
      bus(3'd7, 1'b0, 0, q); chk("R3 status", q, 16'h0048);
      if (i == 10) begin
        bus(3'd7, 1'b1, 16'h00E7, q); // R9 ignored in data-out
        bus(3'd7, 1'b0, 0, q); chk("R9 xfer hold", q, 16'h0048);
      end
      bus(3'd0, 1'b0, 0, q); chk("R3 word", q, id_exp(i));
    end
    bus(3'd7, 1'b0, 0, q); chk("R4 status end", q, 16'h0040);
    bus(3'd0, 1'b0, 0, q); chk("R4 extra word", q, 16'h0000);

    // R10 absent device 1
    bus(3'd6, 1'b1, 16'h0050, q);
    bus(3'd7, 1'b1, 16'h00E7, q);
    chk("R10 irq", {15'd0, irq}, 16'h0);
    bus(3'd7, 1'b0, 0, q); chk("R10 status", q, 16'h0040);
    bus(3'd7, 1'b1, 16'h0012, q);
    bus(3'd1, 1'b0, 0, q); chk("R10 error", q, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule